// File: doc/BRIEF.md
# Digit-Serial GF(2^k) Multiply-Accumulate Unit

This unit evaluates R = A·(B+D) + C reduced modulo a field polynomial P, over the binary extension field GF(2^83). It serves as the arithmetic core for elliptic and hyperelliptic curve point and divisor formulas. All field addition is bitwise XOR. The multiplier operand B+D is formed first. It is then consumed twelve bits at a time, highest digit first.

After each digit the running partial product is shifted and folded back below degree 83 by a regular chain of conditional XORs against P. The low coefficients of P come in as an operand together with the data. Because of this, any degree-83 polynomial whose leading term is implicit can be used without changing the hardware. Tying D to zero gives the plain A·B + C form.

Software or a sequencer puts all five operands on the inputs and pulses start. A fixed number of cycles later a one-cycle done pulse appears. The result is then held on the output.

Top module: `gf2m_mac`

## Requirements
- R1: While reset is asserted and right after it is released, busy and done are 0 and result is all zeros.
- R2: result equals A·(B XOR D) XOR C modulo the polynomial x^83 + P(x). Here op_p bit i is the coefficient of x^i for i in 0..82, and bit i of every operand is the coefficient of x^i.
- R3: With op_d equal to zero, result equals A·B XOR C modulo the same polynomial.
- R4: An accepted start is one sampled while busy is 0. After it, busy is high for exactly 7 clock cycles, which is ceil(83/12). done rises in the cycle right after busy falls, whatever the operand values are.
- R5: done is high for exactly one cycle per accepted start.
- R6: A start sampled while busy is 1 is ignored. It does not change the result of the operation in progress, and it does not add or move a done pulse.
- R7: result changes only in the cycle in which done is asserted. It keeps its value between operations and while a new operation is running.
- R8: The reduction polynomial is taken from op_p at each accepted start. Different polynomials, including dense ones, give results reduced modulo each of them.
- R9: The operand inputs are sampled only at an accepted start. Changing them while busy does not affect the result.
- R10: Boundary operands behave as field arithmetic requires. A = 0 yields C. A = 1 with D = 0 yields B XOR C. All-ones operands reduce correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| op_a | input | 83 | Multiplicand A |
| op_b | input | 83 | Multiplier term B |
| op_c | input | 83 | Accumulate term C |
| op_d | input | 83 | Multiplier addend D (zero for A·B+C) |
| op_p | input | 83 | Coefficients of the reduction polynomial below x^83 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | 83 | Reduced result, held until the next completion |

## Verification
The properties assume that rst_n is held low over at least one rising edge before any operation. They also assume that start is a synchronous level sampled at rising edges. The properties make no assumption about operand values, because the latency and pulse shape must not depend on them.

The bench changes inputs only at falling edges and holds start for a single cycle when it wants an operation accepted. Deliberate starts during busy are placed well inside the seven-cycle window, so they cannot be confused with a legal back-to-back start.

// File: rtl/gf2m_pkg.sv
package gf2m_pkg;
    // Default field degree and digit width of the multiplier scan.
    localparam int FIELD_BITS = 83;
    localparam int DIGIT_BITS = 12;

    // Number of digit steps needed to cover a k-bit multiplier.
    function automatic int digit_steps(input int k, input int d);
        return (k + d - 1) / d;
    endfunction
endpackage

// File: rtl/gf2m_digit_mul.sv
// Carry-free product of a k-bit polynomial with one d-bit digit.
module gf2m_digit_mul #(
    parameter int K   = gf2m_pkg::FIELD_BITS,
    parameter int DIG = gf2m_pkg::DIGIT_BITS
) (
    input  logic [K-1:0]       a,
    input  logic [DIG-1:0]     digit,
    output logic [K+DIG-2:0]   pp
);
    localparam int PW = K + DIG - 1;

    logic [PW-1:0] term [DIG];

    for (genvar j = 0; j < DIG; j++) begin : g_term
        assign term[j] = digit[j] ? ({{(DIG-1){1'b0}}, a} << j) : '0;
    end

    always_comb begin
        pp = '0;
        for (int j = 0; j < DIG; j++) begin
            pp = pp ^ term[j];
        end
    end
endmodule

// File: rtl/gf2m_reduce.sv
// Folds a (k+d)-bit polynomial below degree k, one top bit at a time,
// using the low coefficients of a monic degree-k polynomial.
module gf2m_reduce #(
    parameter int K   = gf2m_pkg::FIELD_BITS,
    parameter int DIG = gf2m_pkg::DIGIT_BITS
) (
    input  logic [K+DIG-1:0] w,
    input  logic [K-1:0]     plow,
    output logic [K-1:0]     r
);
    logic [K+DIG-1:0] acc;

    always_comb begin
        acc = w;
        for (int j = DIG - 1; j >= 0; j--) begin
            if (acc[K+j]) begin
                acc[j +: K] = acc[j +: K] ^ plow;
                acc[K+j]    = 1'b0;
            end
        end
        r = acc[K-1:0];
    end
endmodule

// File: rtl/gf2m_mac.sv
// Digit-serial A*(B+D)+C mod P over GF(2^K), most significant digit first.
module gf2m_mac #(
    parameter int K   = gf2m_pkg::FIELD_BITS,
    parameter int DIG = gf2m_pkg::DIGIT_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [K-1:0] op_a,
    input  logic [K-1:0] op_b,
    input  logic [K-1:0] op_c,
    input  logic [K-1:0] op_d,
    input  logic [K-1:0] op_p,
    output logic         busy,
    output logic         done,
    output logic [K-1:0] result
);
    localparam int NDIG = gf2m_pkg::digit_steps(K, DIG);
    localparam int MW   = NDIG * DIG;
    localparam int CW   = $clog2(NDIG + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(NDIG - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] left;
        logic [K-1:0]  a;
        logic [K-1:0]  c;
        logic [K-1:0]  p;
        logic [MW-1:0] m;
        logic [K-1:0]  z;
        logic [K-1:0]  res;
    } mac_state_t;

    mac_state_t st_d, st_q;

    logic [DIG-1:0]     cur_digit;
    logic [K+DIG-2:0]   part_prod;
    logic [K+DIG-1:0]   step_sum;
    logic [K-1:0]       z_next;

    assign cur_digit = st_q.m[MW-1 -: DIG];

    gf2m_digit_mul #(.K(K), .DIG(DIG)) u_pp (
        .a     (st_q.a),
        .digit (cur_digit),
        .pp    (part_prod)
    );

    // Shift the accumulator up one digit and add the new partial product.
    assign step_sum = {st_q.z, {DIG{1'b0}}} ^ {1'b0, part_prod};

    gf2m_reduce #(.K(K), .DIG(DIG)) u_red (
        .w    (step_sum),
        .plow (st_q.p),
        .r    (z_next)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy         = 1'b1;
                st_d.left         = LAST_IDX;
                st_d.a            = op_a;
                st_d.c            = op_c;
                st_d.p            = op_p;
                st_d.m            = '0;
                st_d.m[K-1:0]     = op_b ^ op_d;
                st_d.z            = '0;
            end
        end else begin
            st_d.z = z_next;
            st_d.m = st_q.m << DIG;
            if (st_q.left == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.res  = z_next ^ st_q.c;
            end else begin
                st_d.left = st_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign result = st_q.res;
endmodule

// File: rtl/gf2m_mac_chk.sv
module gf2m_mac_chk #(
    parameter int K    = 83,
    parameter int NDIG = 7
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [K-1:0] result
);
    localparam int CW = $clog2(NDIG + 2);

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (start && !busy) begin
            busy_cnt <= '0;
        end else if (busy && busy_cnt != CW'(NDIG + 1)) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    // R5: completion is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: done arrives exactly NDIG busy cycles after acceptance
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt == CW'(NDIG)));

    // R4: busy never outlasts the fixed digit count
    p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= CW'(NDIG));

    // R4: done follows the falling edge of busy
    p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R7: result moves only together with done
    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R6: a start seen while busy does not end or restart the operation early
    p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && busy_cnt < CW'(NDIG - 1)) |=> busy);
endmodule

bind gf2m_mac gf2m_mac_chk #(.K(K), .NDIG(NDIG)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/sim_gf2m_mac.sv
`timescale 1ns/1ps
module sim_gf2m_mac;
    localparam int K   = 83;
    localparam int LAT = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [K-1:0] op_a = '0, op_b = '0, op_c = '0, op_d = '0, op_p = '0;
    logic         busy, done;
    logic [K-1:0] result;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    gf2m_mac u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d), .op_p(op_p),
        .busy(busy), .done(done), .result(result)
    );

    localparam logic [K-1:0] P_SPARSE = 83'h95;  // x^7+x^4+x^2+1
    localparam logic [K-1:0] ONES     = {K{1'b1}};

    function automatic logic [K-1:0] rnd83();
        logic [95:0] t;
        t = {$urandom, $urandom, $urandom};
        return t[K-1:0];
    endfunction

    // Full schoolbook product, then reduction from the top down.
    function automatic logic [K-1:0] model(input logic [K-1:0] a, b, c, d, p);
        logic [2*K-1:0] prod;
        logic [K-1:0]   m;
        prod = '0;
        m = b ^ d;
        for (int i = 0; i < K; i++)
            if (m[i]) prod = prod ^ ({{K{1'b0}}, a} << i);
        for (int i = 2*K-1; i >= K; i--)
            if (prod[i]) begin
                prod[i] = 1'b0;
                prod[i-K +: K] = prod[i-K +: K] ^ p;
            end
        return prod[K-1:0] ^ c;
    endfunction

    task automatic check_val(input string tag, input logic [K-1:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input int act, exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load(input logic [K-1:0] a, b, c, d, p);
        op_a = a; op_b = b; op_c = c; op_d = d; op_p = p;
    endtask

    // Pulse start, return the number of falling edges until done.
    task automatic run_op(output int lat);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk); lat++;
        end
    endtask

    task automatic op_check(input string tag, input logic [K-1:0] a, b, c, d, p);
        int lat;
        load(a, b, c, d, p);
        run_op(lat);
        check_int({tag, " latency R4"}, lat, LAT);
        check_val(tag, result, model(a, b, c, d, p));
        @(negedge clk);
        check_int({tag, " pulse R5"}, int'(done), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_int("R1 busy", int'(busy), 0);
        check_int("R1 done", int'(done), 0);
        check_val("R1 result", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_int("R1 busy after release", int'(busy), 0);
        check_val("R1 result after release", result, '0);
    endtask

    task automatic t_fused();
        for (int i = 0; i < 6; i++)
            op_check("R2 fused", rnd83(), rnd83(), rnd83(), rnd83(), P_SPARSE);
    endtask

    task automatic t_plain();
        for (int i = 0; i < 4; i++)
            op_check("R3 plain", rnd83(), rnd83(), rnd83(), '0, P_SPARSE);
    endtask

    task automatic t_poly();
        op_check("R8 dense poly", rnd83(), rnd83(), rnd83(), rnd83(), ONES);
        for (int i = 0; i < 3; i++)
            op_check("R8 random poly", rnd83(), rnd83(), rnd83(), rnd83(), rnd83());
    endtask

    task automatic t_bounds();
        logic [K-1:0] b, c;
        b = rnd83(); c = rnd83();
        op_check("R10 zero A", '0, b, c, rnd83(), P_SPARSE);
        check_val("R10 zero A gives C", result, c);
        op_check("R10 unit A", 83'h1, b, c, '0, P_SPARSE);
        check_val("R10 unit A gives B^C", result, b ^ c);
        op_check("R10 all ones", ONES, ONES, ONES, '0, P_SPARSE);
        op_check("R10 top bits", {1'b1, {(K-1){1'b0}}}, {1'b1, {(K-1){1'b0}}}, '0, '0, ONES);
    endtask

    task automatic t_busy_start();
        logic [K-1:0] a, b, c, d, exp;
        int lat, extra;
        a = rnd83(); b = rnd83(); c = rnd83(); d = rnd83();
        exp = model(a, b, c, d, P_SPARSE);
        load(a, b, c, d, P_SPARSE);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        lat = 0;
        @(negedge clk); lat++;
        load(rnd83(), rnd83(), rnd83(), rnd83(), ONES);
        start = 1'b1;
        @(negedge clk); lat++;
        start = 1'b0;
        while (!done && lat < 40) begin
            @(negedge clk); lat++;
        end
        check_int("R6 latency unchanged", lat, LAT);
        check_val("R6 result of first op", result, exp);
        extra = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check_int("R6 no extra done", extra, 0);
    endtask

    task automatic t_operand_change();
        logic [K-1:0] a, b, c, d, exp;
        int lat;
        a = rnd83(); b = rnd83(); c = rnd83(); d = rnd83();
        exp = model(a, b, c, d, P_SPARSE);
        load(a, b, c, d, P_SPARSE);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk); lat++;
            load(rnd83(), rnd83(), rnd83(), rnd83(), rnd83());
        end
        check_val("R9 inputs sampled at start", result, exp);
    endtask

    task automatic t_hold();
        logic [K-1:0] prev;
        int bad;
        op_check("R7 setup", rnd83(), rnd83(), rnd83(), rnd83(), P_SPARSE);
        prev = result;
        load(rnd83(), rnd83(), rnd83(), rnd83(), P_SPARSE);
        repeat (4) @(negedge clk);
        check_val("R7 idle hold", result, prev);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        bad = 0;
        for (int i = 0; i < LAT - 1; i++) begin
            @(negedge clk);
            if (result !== prev) bad++;
        end
        check_int("R7 hold while busy", bad, 0);
        @(negedge clk);
        check_val("R7 new result", result, model(op_a, op_b, op_c, op_d, op_p));
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_fused();
                t_plain();
                t_poly();
                t_bounds();
                t_busy_start();
                t_operand_change();
                t_hold();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule